// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address stream for a single read or write burst in a two-bank synchronous graphics memory. A column command arrives as a one-cycle start strobe. It carries the start column, the bank, the direction and an auto-precharge request. From the next cycle on, the block presents one column address per clock in which clock enable is high. The order of these addresses depends on the programmed burst length and burst type. The block marks the final beat of every burst of fixed length.

A full-page burst walks the whole 256-column row and wraps back to column 0. It runs until a stop request or a new command ends it. A stop request cuts any burst short. A burst-read-single-write mode turns every write into a single beat and leaves reads at the programmed length. When the command asked for auto precharge, the block raises a one-cycle precharge request, tagged with the bank, once the burst ends. Command decoding, data movement and timing checks belong to the surrounding controller.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and right after it, `col_valid`, `col_last` and `pre_req` are low and `col_addr` is 0. `col_addr` is 0 in every cycle in which `col_valid` is low.
- R2: A start strobe sampled with `cke` high makes `col_valid` high in the next cycle, with `col_addr` equal to the start column. This is beat 0.
- R3: The length code `mode_len` selects the beat count: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and the reserved codes 4 to 6 give 1 beat. `col_last` is high only on the final beat. `col_valid` is low in the cycle after the final beat.
- R4: With `mode_interleave` low and burst length L, beat k carries `(start & ~(L-1)) | ((start + k) & (L-1))`. The address wraps inside the aligned block of L columns.
- R5: With `mode_interleave` high and burst length L, beat k carries `(start & ~(L-1)) | ((start ^ k) & (L-1))`.
- R6: Code 7 selects a full-page burst. It counts up by one column, wraps from 255 to 0 and never raises `col_last`. `mode_interleave` has no effect on it.
- R7: When `cke` is sampled low, the address, valid and last outputs keep their values in the next cycle. A start or stop sampled in that same cycle is ignored.
- R8: A stop request sampled with `cke` high during a burst, and with no start strobe, makes the current beat the final one, so `col_valid` is low in the next cycle. A stop request while idle has no effect.
- R9: When `mode_brsw` is high, a write command (`cmd_write` = 1) gives a single beat. Reads, and writes with `mode_brsw` low, use the programmed length.
- R10: If `cmd_autopre` was set at the start, `pre_req` is high for exactly one cycle, the cycle after the final beat, whether the burst ended normally or by a stop. In that cycle `pre_bank` equals the burst's bank.
- R11: A start strobe during a burst restarts the sequence at the new column with the new settings. The abandoned burst produces no precharge request.
- R12: Length, type and mode inputs are captured at the start strobe. Changing them mid-burst does not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; low freezes the burst |
| cmd_start | input | 1 | One-cycle column command strobe |
| cmd_write | input | 1 | Command direction, 1 = write |
| cmd_col | input | 8 | Start column |
| cmd_bank | input | 1 | Target bank |
| cmd_autopre | input | 1 | Auto precharge requested with the command |
| burst_stop | input | 1 | Stop request for the running burst |
| mode_len | input | 3 | Burst length code |
| mode_interleave | input | 1 | 1 = interleaved order, 0 = linear |
| mode_brsw | input | 1 | Burst-read-single-write mode |
| col_addr | output | 8 | Column address of the current beat |
| col_valid | output | 1 | A beat is presented this cycle |
| col_last | output | 1 | Current beat is the final one |
| pre_req | output | 1 | One-cycle self-timed precharge request |
| pre_bank | output | 1 | Bank to precharge when pre_req is high |

## Verification
The outputs come straight from the held burst state, so a corrupted beat counter, origin or mask shows on `col_addr` in the very cycle after the faulty update. A wrong captured length shows up as `col_last` on the wrong beat, or as `col_valid` dropping one or more cycles early or late. A lost auto-precharge flag or bank shows up one cycle after the final beat, as a missing or mis-tagged `pre_req` pulse. A freeze that leaks is visible in the first cycle after `cke` is sampled low.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    localparam int COL_W  = 8;
    localparam int BANK_W = 1;
    localparam int LEN_W  = 3;

    typedef logic [COL_W-1:0]  col_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic [LEN_W-1:0] {
        BL_1    = 3'd0,
        BL_2    = 3'd1,
        BL_4    = 3'd2,
        BL_8    = 3'd3,
        BL_PAGE = 3'd7
    } bl_code_e;

    // Shape of a burst: which low address bits the beat counter owns.
    typedef struct packed {
        col_t mask;
        logic page;
        logic ilv;
    } shape_t;

    typedef struct packed {
        logic   active;
        col_t   beat;
        col_t   origin;
        shape_t shape;
        bank_t  bank;
        logic   autopre;
    } burst_st_t;

    function automatic col_t beat_col(col_t origin, col_t beat, shape_t sh);
        col_t off;
        off = sh.ilv ? (origin ^ beat) : (origin + beat);
        return (origin & ~sh.mask) | (off & sh.mask);
    endfunction
endpackage

// File: rtl/bcg_shape_dec.sv
module bcg_shape_dec
    import bcg_pkg::*;
(
    input  logic [LEN_W-1:0] len_code,
    input  logic             ilv,
    input  logic             brsw,
    input  logic             is_write,
    output shape_t           shape
);
    always_comb begin
        shape = '0;
        case (len_code)
            BL_2:    shape.mask = col_t'(1);
            BL_4:    shape.mask = col_t'(3);
            BL_8:    shape.mask = col_t'(7);
            BL_PAGE: begin
                shape.mask = '1;
                shape.page = 1'b1;
            end
            default: shape.mask = '0;
        endcase
        if (brsw && is_write) begin
            shape.mask = '0;
            shape.page = 1'b0;
        end
        shape.ilv = ilv & ~shape.page;
    end
endmodule

// File: rtl/bcg_seq.sv
module bcg_seq
    import bcg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cke,
    input  logic      load,
    input  col_t      load_col,
    input  shape_t    load_shape,
    input  bank_t     load_bank,
    input  logic      load_ap,
    input  logic      stop,
    output burst_st_t st,
    output logic      is_last,
    output logic      pre_req,
    output bank_t     pre_bank
);
    logic finish;

    assign is_last = st.active & ~st.shape.page & (st.beat == st.shape.mask);
    assign finish  = cke & ~load & st.active & (is_last | stop);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            pre_req  <= 1'b0;
            pre_bank <= '0;
        end else begin
            pre_req <= finish & st.autopre;
            if (finish && st.autopre)
                pre_bank <= st.bank;
            if (cke) begin
                if (load) begin
                    st.active  <= 1'b1;
                    st.beat    <= '0;
                    st.origin  <= load_col;
                    st.shape   <= load_shape;
                    st.bank    <= load_bank;
                    st.autopre <= load_ap;
                end else if (finish) begin
                    st.active <= 1'b0;
                end else if (st.active) begin
                    st.beat <= st.beat + col_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
    import bcg_pkg::*;
(
    input  burst_st_t st,
    output col_t      addr
);
    assign addr = st.active ? beat_col(st.origin, st.beat, st.shape) : '0;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cke,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic             cmd_autopre,
    input  logic             burst_stop,
    input  logic [LEN_W-1:0] mode_len,
    input  logic             mode_interleave,
    input  logic             mode_brsw,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic             pre_req,
    output logic [BANK_W-1:0] pre_bank
);
    shape_t    next_shape;
    burst_st_t st;

    bcg_shape_dec u_dec (
        .len_code (mode_len),
        .ilv      (mode_interleave),
        .brsw     (mode_brsw),
        .is_write (cmd_write),
        .shape    (next_shape)
    );

    bcg_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cke        (cke),
        .load       (cmd_start),
        .load_col   (cmd_col),
        .load_shape (next_shape),
        .load_bank  (cmd_bank),
        .load_ap    (cmd_autopre),
        .stop       (burst_stop),
        .st         (st),
        .is_last    (col_last),
        .pre_req    (pre_req),
        .pre_bank   (pre_bank)
    );

    bcg_addr_map u_map (
        .st   (st),
        .addr (col_addr)
    );

    assign col_valid = st.active;
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk
    import bcg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cke,
    input logic             cmd_start,
    input logic             cmd_write,
    input logic [COL_W-1:0] cmd_col,
    input logic [BANK_W-1:0] cmd_bank,
    input logic             cmd_autopre,
    input logic             burst_stop,
    input logic [LEN_W-1:0] mode_len,
    input logic             mode_interleave,
    input logic             mode_brsw,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             col_last,
    input logic             pre_req,
    input logic [BANK_W-1:0] pre_bank
);
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (cke && cmd_start) |=> (col_valid && col_addr == $past(cmd_col)));

    assert_last_valid_R3: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

    assert_end_R3: assert property (@(posedge clk) disable iff (rst)
        (cke && col_last && !cmd_start) |=> !col_valid);

    assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (cke && col_valid && !col_last && !burst_stop && !cmd_start)
        |=> (col_valid && col_addr != $past(col_addr)));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (!cke && !rst) |=> ($stable(col_addr) && $stable(col_valid) && $stable(col_last)));

    assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (cke && burst_stop && col_valid && !cmd_start) |=> !col_valid);

    assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        pre_req |=> !pre_req);

    assert_after_end_R10: assert property (@(posedge clk) disable iff (rst)
        pre_req |-> !col_valid);
endmodule

bind burst_col_gen bcg_chk u_chk (.*);

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b1;
    logic       cmd_start = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_col = 8'h00;
    logic [0:0] cmd_bank = 1'b0;
    logic       cmd_autopre = 1'b0;
    logic       burst_stop = 1'b0;
    logic [2:0] mode_len = 3'd0;
    logic       mode_interleave = 1'b0;
    logic       mode_brsw = 1'b0;
    logic [7:0] col_addr;
    logic       col_valid;
    logic       col_last;
    logic       pre_req;
    logic [0:0] pre_bank;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    burst_col_gen u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cmd_start(cmd_start),
        .cmd_write(cmd_write), .cmd_col(cmd_col), .cmd_bank(cmd_bank),
        .cmd_autopre(cmd_autopre), .burst_stop(burst_stop),
        .mode_len(mode_len), .mode_interleave(mode_interleave),
        .mode_brsw(mode_brsw), .col_addr(col_addr), .col_valid(col_valid),
        .col_last(col_last), .pre_req(pre_req), .pre_bank(pre_bank)
    );

    typedef struct packed {
        logic [7:0] col;
        logic [2:0] len;
        logic       ilv;
        logic       brsw;
        logic       wr;
        logic       ap;
        logic       bank;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h05, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{8'h05, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'h0D, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'h0D, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'h3B, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{8'h3B, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'h3B, 3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        '{8'h3B, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{8'hA2, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'hFE, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_len(logic [2:0] len, logic brsw, logic wr);
        if (brsw && wr) return 1;
        case (len)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 256;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] exp_addr(logic [7:0] s, int k, int len, logic ilv);
        logic [7:0] m;
        logic [7:0] kk;
        kk = 8'(k);
        if (len == 256) return s + kk;
        m = 8'(len - 1);
        if (ilv) return (s & ~m) | ((s ^ kk) & m);
        return (s & ~m) | ((s + kk) & m);
    endfunction

    // Called at a falling edge; returns at the falling edge showing beat 0.
    task automatic issue(input logic [7:0] col, input logic [2:0] len, input logic ilv,
                         input logic brsw, input logic wr, input logic ap, input logic bank);
        cmd_col = col; mode_len = len; mode_interleave = ilv; mode_brsw = brsw;
        cmd_write = wr; cmd_autopre = ap; cmd_bank = bank; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 32'(col_valid), 0);
        check("R1 addr in reset", 32'(col_addr), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", 32'(col_valid), 0);
        check("R1 last after reset", 32'(col_last), 0);
        check("R1 pre_req after reset", 32'(pre_req), 0);

        // Vector walk: R2 R3 R4 R5 R9 R10
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            int   n = exp_len(t.len, t.brsw, t.wr);
            issue(t.col, t.len, t.ilv, t.brsw, t.wr, t.ap, t.bank);
            for (int k = 0; k < n; k++) begin
                check("R2 valid", 32'(col_valid), 1);
                check(t.ilv ? "R5 addr" : "R4 addr", 32'(col_addr),
                      32'(exp_addr(t.col, k, n, t.ilv)));
                check((t.brsw && t.wr) ? "R9 last" : "R3 last", 32'(col_last),
                      32'(k == n - 1));
                @(negedge clk);
            end
            check((t.brsw && t.wr) ? "R9 end" : "R3 end", 32'(col_valid), 0);
            check("R10 pre_req", 32'(pre_req), 32'(t.ap));
            if (t.ap) check("R10 pre_bank", 32'(pre_bank), 32'(t.bank));
            check("R1 addr idle", 32'(col_addr), 0);
        end

        // R6 full page with wrap, interleave ignored, then stop (R8) with auto precharge (R10)
        issue(8'hFE, 3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            check("R6 addr", 32'(col_addr), 32'(8'(8'hFE + 8'(k))));
            check("R6 no last", 32'(col_last), 0);
            if (k == 3) burst_stop = 1'b1;
            @(negedge clk);
        end
        burst_stop = 1'b0;
        check("R8 stop ends", 32'(col_valid), 0);
        check("R10 pre_req after stop", 32'(pre_req), 1);
        check("R10 pre_bank after stop", 32'(pre_bank), 0);
        @(negedge clk);
        check("R10 single pulse", 32'(pre_req), 0);

        // R8 stop while idle
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        check("R8 idle stop valid", 32'(col_valid), 0);
        check("R8 idle stop pre_req", 32'(pre_req), 0);

        // R7 clock-enable freeze
        issue(8'h10, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R7 before freeze", 32'(col_addr), 32'h12);
        cke = 1'b0;
        for (int k = 0; k < 3; k++) begin
            burst_stop = (k == 1);
            @(negedge clk);
            check("R7 frozen addr", 32'(col_addr), 32'h12);
            check("R7 frozen valid", 32'(col_valid), 1);
        end
        burst_stop = 1'b0;
        cke = 1'b1;
        for (int k = 3; k < 8; k++) begin
            @(negedge clk);
            check("R7 resume addr", 32'(col_addr), 32'(8'h10 + 8'(k)));
        end
        check("R7 resume last", 32'(col_last), 1);
        @(negedge clk);
        check("R7 end", 32'(col_valid), 0);

        // R11 restart mid-burst drops the old auto precharge
        issue(8'h20, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check("R11 pre-restart", 32'(col_addr), 32'h21);
        issue(8'h47, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R11 restart addr", 32'(col_addr), 32'h47);
        @(negedge clk);
        check("R11 second beat", 32'(col_addr), 32'h46);
        check("R11 last", 32'(col_last), 1);
        @(negedge clk);
        check("R11 end", 32'(col_valid), 0);
        check("R11 no pre_req", 32'(pre_req), 0);

        // R12 settings captured at start
        issue(8'h30, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        mode_len = 3'd0; mode_interleave = 1'b1; mode_brsw = 1'b1; cmd_write = 1'b1;
        for (int k = 0; k < 8; k++) begin
            check("R12 addr", 32'(col_addr), 32'(8'h30 + 8'(k)));
            check("R12 last", 32'(col_last), 32'(k == 7));
            @(negedge clk);
        end
        check("R12 end", 32'(col_valid), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule